// File: doc/BRIEF.md
# Burst-of-four late-write SRAM front end

This block is a single-clock, synthesizable model of the front end of a common-I/O, double-data-rate static RAM. Every operation moves a fixed burst of four words. Each internal clock cycle carries two data beats, one for each clock edge. These appear as an even lane and an odd lane. A command is made of an active-low load strobe, a read-select level and a start address. The block generates the four burst word addresses itself. They wrap inside an aligned group of four words.

Write data arrives one cycle after its command. Each beat carries its own active-low byte enables. The data is first parked in a one-burst write buffer. It moves into the storage array when the next write burst begins. A read that targets words still in the buffer receives the buffered bytes. The older array contents fill in the bytes that the buffered write did not enable.

Read data comes back two beats per cycle. An output-enable level stands in for the bus leaving high impedance. A command that arrives while the previous burst still owns the next cycle is dropped, and a one-cycle error pulse reports it.

Top module: `ddrb4_sram_front`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `rdOutEn` and `protoErr` are low and both read lanes are zero.
- R2: A rising edge with `loadN` low accepts a command: `readSel` = 1 selects a read and `readSel` = 0 selects a write. With `loadN` high the edge is a no-operation. It changes no stored word and raises no output enable, whatever the other inputs carry.
- R3: For a read accepted at edge t, the even and odd lanes hold beats 0 and 1 after edge t+1 and beats 2 and 3 after edge t+2. `rdOutEn` is high for exactly those cycles and low in the cycle after edge t.
- R4: Beat i of a burst started at address A addresses the word whose upper bits equal A's and whose two low bits equal (A[1:0] + i) mod 4.
- R5: For a write accepted at edge t, beats 0 and 1 are taken from `wrEven`/`wrOdd` with `wrEnEvenN`/`wrEnOddN` at edge t+1, and beats 2 and 3 at edge t+2. The lane values at any other edge are never stored.
- R6: Byte enables are active low. Enable bit b of a beat controls data bits [9b+8:9b] of that beat's word. A beat with every enable bit high leaves its word unchanged.
- R7: A read of a word written by the most recent write burst returns the newly written bytes, merged with the older contents of the bytes that were not enabled.
- R8: Data held in the write buffer is committed to the array when the next write burst starts. It stays readable after any number of later writes to other groups.
- R9: A no-operation does not cut short a read burst in progress. `rdOutEn` falls in the cycle after the last beat pair unless another read follows, and both read lanes are zero whenever `rdOutEn` is low.
- R10: Reads accepted two cycles apart produce an unbroken run of `rdOutEn` with four beat pairs in order.
- R11: A command presented at the edge right after an accepted command is ignored, with no read output and no array change. `protoErr` is high for exactly the one cycle after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on its rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| loadN | input | 1 | Command strobe, active low |
| readSel | input | 1 | 1 = read, 0 = write, sampled with `loadN` |
| cmdAddr | input | ADDR_W | Burst start word address |
| wrEven | input | 9*NUM_BYTES | Write data for beats 0 and 2 |
| wrOdd | input | 9*NUM_BYTES | Write data for beats 1 and 3 |
| wrEnEvenN | input | NUM_BYTES | Active-low byte enables for the even-lane beat |
| wrEnOddN | input | NUM_BYTES | Active-low byte enables for the odd-lane beat |
| rdEven | output | 9*NUM_BYTES | Read data for beats 0 and 2 |
| rdOdd | output | 9*NUM_BYTES | Read data for beats 1 and 3 |
| rdOutEn | output | 1 | High while the read lanes drive valid data |
| protoErr | output | 1 | One-cycle pulse for an ignored command |

## Verification
A phase register that slips shows up within the next read. The output-enable window then opens one cycle early or late, and the beat pair seen in the first window cycle is the wrong one. A wrong buffer slot or a wrong merge shows as bad bytes on the read that immediately follows a write, within three cycles of that read's command. A fault in the commit path stays hidden while the buffer still answers. It shows only once a second write has displaced the buffer and the group is read back from the array. For that reason every group is read again after later writes.

// File: rtl/ddrb4_pkg.sv
package ddrb4_pkg;

  // Width of one byte lane, including its ninth bit.
  localparam int BYTE_W = 9;
  // Fixed burst length and number of beats moved per internal cycle.
  localparam int BURST_LEN = 4;
  localparam int LANES = 2;

  // Strobes from the control to the datapath.
  typedef struct packed {
    logic rdFirst;   // load beats 0/1 onto the read lanes
    logic rdSecond;  // load beats 2/3 onto the read lanes
    logic wrFirst;   // capture beats 0/1, commit the old buffer
    logic wrSecond;  // capture beats 2/3
  } beatStrobe_t;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_FIRST  = 2'd1,
    PH_SECOND = 2'd2
  } burstPhase_t;

endpackage

// File: rtl/ddrb4_ctrl.sv
module ddrb4_ctrl
  import ddrb4_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadN,
  input  logic              readSel,
  input  logic [ADDR_W-1:0] cmdAddr,
  output beatStrobe_t       strb,
  output logic [ADDR_W-1:0] burstAddr,
  output logic              protoErr
);

  burstPhase_t phaseQ, phaseD;
  logic        opReadQ;
  logic [ADDR_W-1:0] startAddrQ;
  logic        errQ;

  logic cmdSeen;
  logic cmdAccept;
  logic cmdClash;

  // A command is only legal when the current burst does not own the next cycle.
  assign cmdSeen   = !loadN;
  assign cmdAccept = cmdSeen && (phaseQ != PH_FIRST);
  assign cmdClash  = cmdSeen && (phaseQ == PH_FIRST);

  always_comb begin
    if (cmdAccept) begin
      phaseD = PH_FIRST;
    end else if (phaseQ == PH_FIRST) begin
      phaseD = PH_SECOND;
    end else begin
      phaseD = PH_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phaseQ     <= PH_IDLE;
      opReadQ    <= 1'b0;
      startAddrQ <= '0;
      errQ       <= 1'b0;
    end else begin
      phaseQ <= phaseD;
      errQ   <= cmdClash;
      if (cmdAccept) begin
        opReadQ    <= readSel;
        startAddrQ <= cmdAddr;
      end
    end
  end

  always_comb begin
    strb.rdFirst  = (phaseQ == PH_FIRST)  &&  opReadQ;
    strb.rdSecond = (phaseQ == PH_SECOND) &&  opReadQ;
    strb.wrFirst  = (phaseQ == PH_FIRST)  && !opReadQ;
    strb.wrSecond = (phaseQ == PH_SECOND) && !opReadQ;
  end

  assign burstAddr = startAddrQ;
  assign protoErr  = errQ;

  // A first-half strobe is always followed by its second half.
  AST_RD_HALVES: assert property (@(posedge clk) disable iff (!rstN)
    strb.rdFirst |=> strb.rdSecond); // R3
  AST_WR_HALVES: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFirst |=> strb.wrSecond); // R5
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdFirst, strb.rdSecond, strb.wrFirst, strb.wrSecond})); // R2
  AST_NOP_NO_START: assert property (@(posedge clk) disable iff (!rstN)
    loadN |=> !(strb.rdFirst || strb.wrFirst)); // R2
  AST_ERR_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> !protoErr); // R11
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |-> $past(!loadN)); // R11

endmodule

// File: rtl/ddrb4_datapath.sv
module ddrb4_datapath
  import ddrb4_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  beatStrobe_t                   strb,
  input  logic [ADDR_W-1:0]             burstAddr,
  input  logic [NUM_BYTES*BYTE_W-1:0]   wrEven,
  input  logic [NUM_BYTES*BYTE_W-1:0]   wrOdd,
  input  logic [NUM_BYTES-1:0]          wrEnEvenN,
  input  logic [NUM_BYTES-1:0]          wrEnOddN,
  output logic [NUM_BYTES*BYTE_W-1:0]   rdEven,
  output logic [NUM_BYTES*BYTE_W-1:0]   rdOdd,
  output logic                          rdOutEn
);

  localparam int DW    = NUM_BYTES * BYTE_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OFS_W = $clog2(BURST_LEN);
  localparam int GRP_W = ADDR_W - OFS_W;

  // Storage array and the one-burst write buffer, indexed by word offset.
  logic [DW-1:0]        mem      [DEPTH];
  logic [DW-1:0]        bufData  [BURST_LEN];
  logic [NUM_BYTES-1:0] bufEnN   [BURST_LEN];
  logic [GRP_W-1:0]     bufGroup;
  logic                 bufValid;

  logic [GRP_W-1:0] curGroup;
  logic [OFS_W-1:0] curOfs;
  logic [OFS_W-1:0] rdBase;
  logic [OFS_W-1:0] wrBase;
  logic             bufHit;
  logic             wrAny;
  logic             rdAny;

  logic [DW-1:0]        laneWord  [LANES];
  logic [OFS_W-1:0]     wrSlot    [LANES];
  logic [DW-1:0]        wrLane    [LANES];
  logic [NUM_BYTES-1:0] wrLaneEnN [LANES];

  assign curGroup = burstAddr[ADDR_W-1:OFS_W];
  assign curOfs   = burstAddr[OFS_W-1:0];
  assign rdBase   = curOfs + (strb.rdSecond ? OFS_W'(2) : OFS_W'(0));
  assign wrBase   = curOfs + (strb.wrSecond ? OFS_W'(2) : OFS_W'(0));
  assign bufHit   = bufValid && (bufGroup == curGroup);
  assign wrAny    = strb.wrFirst || strb.wrSecond;
  assign rdAny    = strb.rdFirst || strb.rdSecond;

  assign wrLane[0]    = wrEven;
  assign wrLane[1]    = wrOdd;
  assign wrLaneEnN[0] = wrEnEvenN;
  assign wrLaneEnN[1] = wrEnOddN;

  // One read-merge path and one write-slot decoder per lane.
  for (genvar ln = 0; ln < LANES; ln++) begin : gLane
    logic [OFS_W-1:0] rdSlot;
    logic [DW-1:0]    merged;

    assign rdSlot       = rdBase + OFS_W'(ln);
    assign wrSlot[ln]   = wrBase + OFS_W'(ln);

    always_comb begin
      merged = mem[{curGroup, rdSlot}];
      for (int b = 0; b < NUM_BYTES; b++) begin
        if (bufHit && !bufEnN[rdSlot][b]) begin
          merged[b*BYTE_W +: BYTE_W] = bufData[rdSlot][b*BYTE_W +: BYTE_W];
        end
      end
    end

    assign laneWord[ln] = merged;
  end

  // Commit the parked burst when the next write burst begins.
  always_ff @(posedge clk) begin
    if (strb.wrFirst && bufValid) begin
      for (int s = 0; s < BURST_LEN; s++) begin
        for (int b = 0; b < NUM_BYTES; b++) begin
          if (!bufEnN[s][b]) begin
            mem[{bufGroup, OFS_W'(s)}][b*BYTE_W +: BYTE_W] <= bufData[s][b*BYTE_W +: BYTE_W];
          end
        end
      end
    end
  end

  // Buffer bookkeeping: group, validity and per-slot enables.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufValid <= 1'b0;
      bufGroup <= '0;
      for (int s = 0; s < BURST_LEN; s++) begin
        bufEnN[s] <= '1;
      end
    end else begin
      if (strb.wrFirst) begin
        bufValid <= 1'b1;
        bufGroup <= curGroup;
        for (int s = 0; s < BURST_LEN; s++) begin
          bufEnN[s] <= '1;
        end
      end
      if (wrAny) begin
        for (int l = 0; l < LANES; l++) begin
          bufEnN[wrSlot[l]] <= wrLaneEnN[l];
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wrAny) begin
      for (int l = 0; l < LANES; l++) begin
        bufData[wrSlot[l]] <= wrLane[l];
      end
    end
  end

  // Read lanes: registered, zero while the bus would float.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdEven  <= '0;
      rdOdd   <= '0;
      rdOutEn <= 1'b0;
    end else if (rdAny) begin
      rdEven  <= laneWord[0];
      rdOdd   <= laneWord[1];
      rdOutEn <= 1'b1;
    end else begin
      rdEven  <= '0;
      rdOdd   <= '0;
      rdOutEn <= 1'b0;
    end
  end

  AST_LANES_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !rdOutEn |-> (rdEven == '0 && rdOdd == '0)); // R9
  AST_EN_FROM_READ: assert property (@(posedge clk) disable iff (!rstN)
    rdOutEn |-> $past(strb.rdFirst || strb.rdSecond)); // R3
  AST_BUF_GROUP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrFirst |=> $stable(bufGroup)); // R8
  AST_BUF_VALID_KEEP: assert property (@(posedge clk) disable iff (!rstN)
    bufValid |=> bufValid); // R8

endmodule

// File: rtl/ddrb4_sram_front.sv
module ddrb4_sram_front
  import ddrb4_pkg::*;
#(
  parameter int ADDR_W    = 6,
  parameter int NUM_BYTES = 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        loadN,
  input  logic                        readSel,
  input  logic [ADDR_W-1:0]           cmdAddr,
  input  logic [NUM_BYTES*9-1:0]      wrEven,
  input  logic [NUM_BYTES*9-1:0]      wrOdd,
  input  logic [NUM_BYTES-1:0]        wrEnEvenN,
  input  logic [NUM_BYTES-1:0]        wrEnOddN,
  output logic [NUM_BYTES*9-1:0]      rdEven,
  output logic [NUM_BYTES*9-1:0]      rdOdd,
  output logic                        rdOutEn,
  output logic                        protoErr
);

  beatStrobe_t       strb;
  logic [ADDR_W-1:0] burstAddr;

  ddrb4_ctrl #(
    .ADDR_W (ADDR_W)
  ) uCtrl (
    .clk       (clk),
    .rstN      (rstN),
    .loadN     (loadN),
    .readSel   (readSel),
    .cmdAddr   (cmdAddr),
    .strb      (strb),
    .burstAddr (burstAddr),
    .protoErr  (protoErr)
  );

  ddrb4_datapath #(
    .ADDR_W    (ADDR_W),
    .NUM_BYTES (NUM_BYTES)
  ) uData (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .burstAddr (burstAddr),
    .wrEven    (wrEven),
    .wrOdd     (wrOdd),
    .wrEnEvenN (wrEnEvenN),
    .wrEnOddN  (wrEnOddN),
    .rdEven    (rdEven),
    .rdOdd     (rdOdd),
    .rdOutEn   (rdOutEn)
  );

endmodule

// File: tb/tb_ddrb4_sram_front.sv
module tb_ddrb4_sram_front;

  localparam int AW    = 4;
  localparam int NB    = 2;
  localparam int DW    = NB * 9;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN;
  logic          loadN;
  logic          readSel;
  logic [AW-1:0] cmdAddr;
  logic [DW-1:0] wrEven, wrOdd;
  logic [NB-1:0] wrEnEvenN, wrEnOddN;
  logic [DW-1:0] rdEven, rdOdd;
  logic          rdOutEn;
  logic          protoErr;

  always #4 clk = ~clk;

  ddrb4_sram_front #(.ADDR_W(AW), .NUM_BYTES(NB)) dut (
    .clk(clk), .rstN(rstN), .loadN(loadN), .readSel(readSel), .cmdAddr(cmdAddr),
    .wrEven(wrEven), .wrOdd(wrOdd), .wrEnEvenN(wrEnEvenN), .wrEnOddN(wrEnOddN),
    .rdEven(rdEven), .rdOdd(rdOdd), .rdOutEn(rdOutEn), .protoErr(protoErr)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  logic [DW-1:0] model [DEPTH];

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int wordOf(int s, int i);
    return (s & ~3) | ((s + i) & 3);
  endfunction

  function automatic logic [DW-1:0] pat(int s, int i, int salt);
    return DW'((s * 613 + i * 97 + salt * 1031 + 5) % (1 << DW));
  endfunction

  // Reference: later writes win per enabled byte (R6, R7).
  task automatic applyWrite(int s, logic [3:0][DW-1:0] d, logic [3:0][NB-1:0] en);
    for (int i = 0; i < 4; i++) begin
      for (int b = 0; b < NB; b++) begin
        if (!en[i][b]) model[wordOf(s, i)][b*9 +: 9] = d[i][b*9 +: 9];
      end
    end
  endtask

  // Starts and ends at a falling edge; lanes hold junk outside the window (R5).
  task automatic doWrite(int s, logic [3:0][DW-1:0] d, logic [3:0][NB-1:0] en);
    loadN = 1'b0; readSel = 1'b0; cmdAddr = AW'(s);
    @(negedge clk);
    loadN = 1'b1; readSel = 1'b1;
    wrEven = d[0]; wrOdd = d[1]; wrEnEvenN = en[0]; wrEnOddN = en[1];
    @(negedge clk);
    wrEven = d[2]; wrOdd = d[3]; wrEnEvenN = en[2]; wrEnOddN = en[3];
    @(negedge clk);
    wrEven = ~d[2]; wrOdd = ~d[3]; wrEnEvenN = '0; wrEnOddN = '0;
    applyWrite(s, d, en);
  endtask

  task automatic doRead(int s, string tag);
    loadN = 1'b0; readSel = 1'b1; cmdAddr = AW'(s);
    @(negedge clk);
    loadN = 1'b1;
    chk({tag, " R3 enable before data"}, 32'(rdOutEn), 32'd0);
    @(negedge clk);
    chk({tag, " R3 enable pair0"}, 32'(rdOutEn), 32'd1);
    chk({tag, " beat0"}, 32'(rdEven), 32'(model[wordOf(s, 0)]));
    chk({tag, " beat1"}, 32'(rdOdd), 32'(model[wordOf(s, 1)]));
    @(negedge clk);
    chk({tag, " R3 enable pair1"}, 32'(rdOutEn), 32'd1);
    chk({tag, " beat2"}, 32'(rdEven), 32'(model[wordOf(s, 2)]));
    chk({tag, " beat3"}, 32'(rdOdd), 32'(model[wordOf(s, 3)]));
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired before the sequence completed");
    finish();
  end

  initial begin
    logic [3:0][DW-1:0] d;
    logic [3:0][NB-1:0] en;

    rstN = 1'b0; loadN = 1'b1; readSel = 1'b1; cmdAddr = '0;
    wrEven = '0; wrOdd = '0; wrEnEvenN = '1; wrEnOddN = '1;
    repeat (3) @(negedge clk);
    chk("R1 reset enable", 32'(rdOutEn), 32'd0);
    chk("R1 reset even lane", 32'(rdEven), 32'd0);
    chk("R1 reset odd lane", 32'(rdOdd), 32'd0);
    chk("R1 reset error", 32'(protoErr), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 after reset enable", 32'(rdOutEn), 32'd0);
    chk("R1 after reset error", 32'(protoErr), 32'd0);

    // Fill every group, then read it back (R5).
    for (int g = 0; g < DEPTH / 4; g++) begin
      for (int i = 0; i < 4; i++) d[i] = pat(g * 4, i, 1);
      en = '0;
      doWrite(g * 4, d, en);
    end
    for (int g = 0; g < DEPTH / 4; g++) doRead(g * 4, "R5 fill");

    // Every start offset: write, read back at once and at a rotated start (R4, R7).
    for (int s = 0; s < DEPTH; s++) begin
      for (int i = 0; i < 4; i++) d[i] = pat(s, i, 2);
      en = '0;
      doWrite(s, d, en);
      doRead(s, "R7 coherent");
      doRead((s & ~3) | ((s + 1) & 3), "R4 wrap");
    end

    // Byte enable patterns cycling through all four codes, including abort (R6).
    for (int s = 0; s < DEPTH; s++) begin
      for (int i = 0; i < 4; i++) begin
        d[i]  = pat(s, i, 3 + s);
        en[i] = NB'((s + i) & 3);
      end
      doWrite(s, d, en);
      doRead(s, "R6 mask");
    end
    for (int i = 0; i < 4; i++) d[i] = pat(9, i, 77);
    en = '1;
    doWrite(5, d, en);
    doRead(5, "R6 full abort");

    // Committed data survives later writes to other groups (R8).
    for (int i = 0; i < 4; i++) d[i] = pat(1, i, 40);
    en = '0;
    doWrite(1, d, en);
    for (int i = 0; i < 4; i++) d[i] = pat(6, i, 41);
    doWrite(6, d, en);
    for (int i = 0; i < 4; i++) d[i] = pat(10, i, 42);
    doWrite(10, d, en);
    for (int g = 0; g < DEPTH / 4; g++) doRead(g * 4, "R8 commit");

    // No-operations with busy-looking inputs change nothing (R2).
    for (int c = 0; c < 6; c++) begin
      loadN = 1'b1; readSel = c[0]; cmdAddr = AW'(c * 3);
      wrEven = pat(c, 0, 90); wrOdd = pat(c, 1, 90); wrEnEvenN = '0; wrEnOddN = '0;
      @(negedge clk);
      chk("R2 nop enable", 32'(rdOutEn), 32'd0);
    end
    for (int g = 0; g < DEPTH / 4; g++) doRead(g * 4, "R2 nop untouched");

    // Read followed by idle: enable drops and lanes are zero (R9).
    doRead(7, "R9 read");
    @(negedge clk);
    chk("R9 enable after burst", 32'(rdOutEn), 32'd0);
    chk("R9 even lane zero", 32'(rdEven), 32'd0);
    chk("R9 odd lane zero", 32'(rdOdd), 32'd0);

    // Two reads two cycles apart (R10).
    loadN = 1'b0; readSel = 1'b1; cmdAddr = AW'(2);
    @(negedge clk);
    loadN = 1'b1;
    @(negedge clk);
    chk("R10 A enable0", 32'(rdOutEn), 32'd1);
    chk("R10 A beat0", 32'(rdEven), 32'(model[wordOf(2, 0)]));
    chk("R10 A beat1", 32'(rdOdd), 32'(model[wordOf(2, 1)]));
    loadN = 1'b0; readSel = 1'b1; cmdAddr = AW'(13);
    @(negedge clk);
    loadN = 1'b1;
    chk("R10 accepted no error", 32'(protoErr), 32'd0);
    chk("R10 A beat2", 32'(rdEven), 32'(model[wordOf(2, 2)]));
    chk("R10 A beat3", 32'(rdOdd), 32'(model[wordOf(2, 3)]));
    @(negedge clk);
    chk("R10 B enable continuous", 32'(rdOutEn), 32'd1);
    chk("R10 B beat0", 32'(rdEven), 32'(model[wordOf(13, 0)]));
    chk("R10 B beat1", 32'(rdOdd), 32'(model[wordOf(13, 1)]));
    @(negedge clk);
    chk("R10 B beat2", 32'(rdEven), 32'(model[wordOf(13, 2)]));
    chk("R10 B beat3", 32'(rdOdd), 32'(model[wordOf(13, 3)]));
    @(negedge clk);
    chk("R10 enable end", 32'(rdOutEn), 32'd0);

    // Write with a read command crowding it (R11).
    for (int i = 0; i < 4; i++) d[i] = pat(3, i, 55);
    en = '0;
    loadN = 1'b0; readSel = 1'b0; cmdAddr = AW'(3);
    @(negedge clk);
    loadN = 1'b0; readSel = 1'b1; cmdAddr = AW'(8);
    wrEven = d[0]; wrOdd = d[1]; wrEnEvenN = '0; wrEnOddN = '0;
    @(negedge clk);
    chk("R11 error pulse", 32'(protoErr), 32'd1);
    loadN = 1'b1;
    wrEven = d[2]; wrOdd = d[3];
    @(negedge clk);
    chk("R11 error cleared", 32'(protoErr), 32'd0);
    chk("R11 no phantom read", 32'(rdOutEn), 32'd0);
    wrEnEvenN = '1; wrEnOddN = '1;
    applyWrite(3, d, en);
    @(negedge clk);
    chk("R11 no phantom read late", 32'(rdOutEn), 32'd0);
    doRead(3, "R11 write kept");

    // Read with a write command crowding it (R11).
    loadN = 1'b0; readSel = 1'b1; cmdAddr = AW'(14);
    @(negedge clk);
    loadN = 1'b0; readSel = 1'b0; cmdAddr = AW'(4);
    wrEven = pat(4, 0, 66); wrOdd = pat(4, 1, 66); wrEnEvenN = '0; wrEnOddN = '0;
    @(negedge clk);
    loadN = 1'b1;
    chk("R11 error on read", 32'(protoErr), 32'd1);
    chk("R11 read beat0", 32'(rdEven), 32'(model[wordOf(14, 0)]));
    chk("R11 read beat1", 32'(rdOdd), 32'(model[wordOf(14, 1)]));
    @(negedge clk);
    chk("R11 error gone", 32'(protoErr), 32'd0);
    chk("R11 read beat2", 32'(rdEven), 32'(model[wordOf(14, 2)]));
    chk("R11 read beat3", 32'(rdOdd), 32'(model[wordOf(14, 3)]));
    @(negedge clk);
    chk("R11 read closed", 32'(rdOutEn), 32'd0);
    wrEnEvenN = '1; wrEnOddN = '1;
    doRead(4, "R11 phantom write absent");
    for (int i = 0; i < 4; i++) d[i] = pat(12, i, 67);
    en = '0;
    doWrite(12, d, en);
    doRead(4, "R11 phantom commit absent");

    finish();
  end

endmodule